// File: doc/BRIEF.md
# Dual-Rail Compelled Serial Transmitter

This block sends bytes to a receiver over two open-drain wires with no shared clock and no baud rate. Each bit is a four-phase exchange. The sender pulls the "one" wire low to send a 1, or the "zero" wire low to send a 0. The receiver answers by pulling the opposite wire low. The sender then lets its wire go, and the receiver lets its answer go. Because every phase waits for the other side, the link runs as fast as the slower end allows.

The host starts a transfer with a byte count and takes bytes through a valid/ready stream. The block keeps a count of the bytes still owed to the current block. A new block sets that count to the block length (11 by default). Each transfer subtracts its byte count. If bytes are still owed when a transfer ends, the block sends a break: a short pulse with both wires low at once. The receiver reads the break as an early end of the block. The pull-up resistors and the wired-AND of the two wires sit outside the block.

Top module: `dualrail_tx`

## Requirements
- R1: After reset, neither drive output is asserted and `busy`, `done` and `in_ready` are low. While `busy` is low, neither wire is driven.
- R2: A 1 bit asserts only `drv_one_low` and a 0 bit asserts only `drv_zero_low`. The drive is held until the opposite wire is sensed low (the acknowledge), then it is removed.
- R3: Before driving any bit, the block waits until both sensed wires read high after the two-flop synchronizer. While either wire is held low by someone else, nothing is driven.
- R4: Each transfer sends `xfer_count` bytes, most significant bit first, eight bits per byte. Each byte is taken from `in_data` in a cycle where `in_valid` and `in_ready` are both high. The block stalls, driving nothing, while no byte is offered.
- R5: On an accepted start, the remaining count is loaded with BLOCK_LEN (11) if `new_block` is high, or kept from the previous transfer if it is low. The count is then reduced by `xfer_count`, and a count at or below zero becomes zero. Reset clears the remaining count to zero.
- R6: If the remaining count is nonzero when the last byte is acknowledged (or at once when `xfer_count` is 0), the block waits for both wires high. It then asserts both drives in the same cycle for BREAK_CYC (4) cycles and removes both in the same cycle.
- R7: If the remaining count is zero at the end of a transfer, no break is sent.
- R8: `busy` is high from the cycle after an accepted start until the transfer ends. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R9: A start while `busy` is high is ignored. It does not change the bytes sent, the break decision or the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| new_block | input | 1 | With start: reload the remaining count to the block length |
| xfer_count | input | CNT_W | Number of bytes in this transfer |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Block takes in_data this cycle if in_valid is high |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| drv_one_low | output | 1 | Enable for pulling the "one" wire low |
| drv_zero_low | output | 1 | Enable for pulling the "zero" wire low |
| sense_one | input | 1 | Level read from the "one" wire |
| sense_zero | input | 1 | Level read from the "zero" wire |

## Verification
The bench pairs the block with a behavioural receiver whose acknowledge delay is set to 0, 2 and 7 cycles. This shows that the sender always waits for the handshake instead of relying on a fixed timing. Data patterns of all zeros, all ones, alternating bits and mixed values check the rail choice and the bit order. A chain of transfers without a block reload, ending either in a break or exactly at the block length, separates the break and no-break decisions. It also shows whether the remaining count carries over correctly. Further runs cover: a wire held low by a third party, a byte stream that stalls, a zero-byte transfer, an oversized count that clamps, and a start pulse issued mid-transfer. Together these isolate the idle wait, the stream stall, the clamp and the ignored start.

// File: rtl/drtx_pkg.sv
// Package: shared state encoding for the dual-rail transmitter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package drtx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_DRIVE,
        ST_BRK_WAIT,
        ST_BRK
    } tx_state_e;
endpackage

// File: rtl/dr_sync.sv
// Multi-stage synchronizer for W asynchronous level inputs.
// Assumes inputs idle high, so every stage resets to ones.
module dr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Purpose: the first stage captures the raw wire levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '1;
        else        stage[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Purpose: each later stage re-times the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '1;
                else        stage[g] <= stage[g-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/drtx_remain.sv
// Remaining-byte counter for the current block.
// On load, the base is either the block length (new block) or the stored
// remainder. The transfer count is subtracted, and the result clamps at zero.
module drtx_remain #(
    parameter int BLOCK_LEN = 11,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             new_block,
    input  logic [CNT_W-1:0] cnt,
    output logic             next_zero,
    output logic             rem_zero
);
    logic [CNT_W-1:0] rem_q, base, rem_next;

    // Purpose: pick the base and subtract the transfer count with clamping.
    always_comb begin
        base     = new_block ? CNT_W'(BLOCK_LEN) : rem_q;
        rem_next = (cnt >= base) ? '0 : base - cnt;
    end

    // Purpose: store the remainder when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)    rem_q <= '0;
        else if (load) rem_q <= rem_next;
    end

    assign next_zero = (rem_next == '0);
    assign rem_zero  = (rem_q == '0);
endmodule

// File: rtl/drtx_shift.sv
// Byte shifter that presents bits most significant first, with a bit index.
// Assumes load and advance are never high in the same cycle.
module drtx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              advance,
    output logic              cur_bit,
    output logic              last_bit
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    // Purpose: load a new byte, or move on to the next bit after an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= data;
            idx_q <= '0;
        end else if (advance) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign cur_bit  = sh_q[DATA_W-1];
    assign last_bit = (idx_q == IDX_W'(DATA_W - 1));
endmodule

// File: rtl/dualrail_tx.sv
// Dual-rail compelled serial transmitter (top).
// Sequences the bytes of a transfer into four-phase bit handshakes and ends a
// short block with a break.
// Assumes: the wires are open-drain with external pull-ups; sense inputs are
// asynchronous; in_data is stable while in_valid is high.
module dualrail_tx
    import drtx_pkg::*;
#(
    parameter int  DATA_W      = 8,
    parameter int  BLOCK_LEN   = 11,
    parameter int  BREAK_CYC   = 4,
    parameter int  SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(BLOCK_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              new_block,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              done,
    output logic              drv_one_low,
    output logic              drv_zero_low,
    input  logic              sense_one,
    input  logic              sense_zero
);
    localparam int BRK_W = $clog2(BREAK_CYC + 1);

    tx_state_e        st, st_nxt;
    logic [1:0]       sync_q;
    logic             sync_one, sync_zero, line_idle, ack_seen;
    logic             take, adv, fin, done_q;
    logic             cur_bit, last_bit, next_zero, rem_zero;
    logic [CNT_W-1:0] bytes_left;
    logic [BRK_W-1:0] brk_cnt;

    dr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sense_one, sense_zero}),
        .q     (sync_q)
    );

    assign sync_one  = sync_q[1];
    assign sync_zero = sync_q[0];
    assign line_idle = sync_one && sync_zero;
    assign ack_seen  = cur_bit ? !sync_zero : !sync_one;

    drtx_remain #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W)) u_remain (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .new_block (new_block),
        .cnt       (xfer_count),
        .next_zero (next_zero),
        .rem_zero  (rem_zero)
    );

    drtx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st == ST_LOAD && in_valid),
        .data     (in_data),
        .advance  (adv),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    // Purpose: next-state logic for byte, bit and break sequencing.
    always_comb begin
        st_nxt = st;
        take   = 1'b0;
        adv    = 1'b0;
        fin    = 1'b0;
        case (st)
            ST_IDLE: if (start) begin
                take = 1'b1;
                if (xfer_count != '0) st_nxt = ST_LOAD;
                else if (!next_zero)  st_nxt = ST_BRK_WAIT;
                else                  fin    = 1'b1;
            end
            ST_LOAD:  if (in_valid)  st_nxt = ST_WAIT;
            ST_WAIT:  if (line_idle) st_nxt = ST_DRIVE;
            ST_DRIVE: if (ack_seen) begin
                adv = 1'b1;
                if (!last_bit)                     st_nxt = ST_WAIT;
                else if (bytes_left != CNT_W'(1))  st_nxt = ST_LOAD;
                else if (!rem_zero)                st_nxt = ST_BRK_WAIT;
                else begin
                    st_nxt = ST_IDLE;
                    fin    = 1'b1;
                end
            end
            ST_BRK_WAIT: if (line_idle) st_nxt = ST_BRK;
            ST_BRK: if (brk_cnt == BRK_W'(BREAK_CYC - 1)) begin
                st_nxt = ST_IDLE;
                fin    = 1'b1;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Purpose: state, byte countdown, break timer and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            bytes_left <= '0;
            brk_cnt    <= '0;
            done_q     <= 1'b0;
        end else begin
            st     <= st_nxt;
            done_q <= fin;
            if (take)                 bytes_left <= xfer_count;
            else if (adv && last_bit) bytes_left <= bytes_left - 1'b1;
            brk_cnt <= (st == ST_BRK) ? brk_cnt + 1'b1 : '0;
        end
    end

    assign in_ready     = (st == ST_LOAD);
    assign busy         = (st != ST_IDLE);
    assign done         = done_q;
    assign drv_one_low  = (st == ST_DRIVE && cur_bit)  || (st == ST_BRK);
    assign drv_zero_low = (st == ST_DRIVE && !cur_bit) || (st == ST_BRK);
endmodule

// File: rtl/dualrail_tx_checker.sv
// Protocol checker for dualrail_tx, attached with bind.
// Assumes sync_one/sync_zero are the synchronized wire levels inside the top.
module dualrail_tx_checker #(
    parameter int BREAK_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic drv1,
    input logic drv0,
    input logic s1,
    input logic s0,
    input logic busy,
    input logic done,
    input logic in_ready
);
    int both_cnt;

    // Purpose: count consecutive cycles with both wires driven.
    always_ff @(posedge clk) begin
        if (!rst_n)           both_cnt <= 0;
        else if (drv1 && drv0) both_cnt <= both_cnt + 1;
        else                  both_cnt <= 0;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!drv1 && !drv0 && !in_ready));

    a_r2_hold_one: assert property (@(posedge clk) disable iff (!rst_n)
        (drv1 && !drv0 && s0) |=> drv1);

    a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (drv0 && !drv1 && s1) |=> drv0);

    a_r3_drive_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv1 || drv0) |-> $past(s1 && s0));

    a_r6_break_starts_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv1 && drv0) |-> $past(!drv1 && !drv0));

    a_r6_break_ends_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv1 && drv0) |-> (!drv1 && !drv0));

    a_r6_break_length: assert property (@(posedge clk) disable iff (!rst_n)
        both_cnt <= BREAK_CYC);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind dualrail_tx dualrail_tx_checker #(.BREAK_CYC(BREAK_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .drv1     (drv_one_low),
    .drv0     (drv_zero_low),
    .s1       (sync_one),
    .s0       (sync_zero),
    .busy     (busy),
    .done     (done),
    .in_ready (in_ready)
);

// File: tb/tb_dualrail_tx.sv
// Bench: behavioural receiver on the wired-AND wires, a byte feeder, and a
// per-clock reference of busy/done/break expectations.
module tb_dualrail_tx;
    localparam int DATA_W    = 8;
    localparam int BLOCK_LEN = 11;
    localparam int BREAK_CYC = 4;
    localparam int CNT_W     = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0, new_block = 1'b0, in_valid = 1'b0;
    logic [CNT_W-1:0]  xfer_count = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_ready, busy, done, drv_one_low, drv_zero_low;
    logic rx_pull_one = 1'b0, rx_pull_zero = 1'b0, ext_one = 1'b0, ext_zero = 1'b0;
    wire  sense_one  = !(drv_one_low  || rx_pull_one  || ext_one);
    wire  sense_zero = !(drv_zero_low || rx_pull_zero || ext_zero);

    dualrail_tx #(.DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN), .BREAK_CYC(BREAK_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .new_block(new_block),
        .xfer_count(xfer_count), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .busy(busy), .done(done),
        .drv_one_low(drv_one_low), .drv_zero_low(drv_zero_low),
        .sense_one(sense_one), .sense_zero(sense_zero)
    );

    int checks = 0, errors = 0, cycles = 0;
    int rx_delay = 2, rx_st = 0, rx_cnt = 0, brk_len = 0, brk_seen = 0, done_cnt = 0;
    int rem_model = 0, exp_cnt = 0;
    bit exp_break = 0, exp_busy = 0, feed_en = 1, pend = 0, monitor_on = 0;
    bit rx_bits[$];
    logic [DATA_W-1:0] src_q[$], exp_bytes[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Receiver model, byte feeder and per-clock reference, all at the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (monitor_on) begin
            case (rx_st)
                0: if (drv_one_low && drv_zero_low) begin
                        brk_seen++; brk_len = 1; rx_st = 3; rx_cnt = 0;
                    end else if (drv_one_low) begin
                        if (rx_cnt >= rx_delay) begin
                            rx_pull_zero = 1; rx_bits.push_back(1'b1); rx_st = 1; rx_cnt = 0;
                        end else rx_cnt++;
                    end else if (drv_zero_low) begin
                        if (rx_cnt >= rx_delay) begin
                            rx_pull_one = 1; rx_bits.push_back(1'b0); rx_st = 2; rx_cnt = 0;
                        end else rx_cnt++;
                    end else begin
                        if (rx_cnt != 0) chk(0, "R2", "drive removed before acknowledge", 0, 1);
                        rx_cnt = 0;
                    end
                1: begin
                    if (drv_zero_low) chk(0, "R2", "zero wire driven during a 1 bit", 1, 0);
                    if (!drv_one_low) begin
                        if (rx_cnt >= rx_delay) begin rx_pull_zero = 0; rx_st = 0; rx_cnt = 0; end
                        else rx_cnt++;
                    end
                end
                2: begin
                    if (drv_one_low) chk(0, "R2", "one wire driven during a 0 bit", 1, 0);
                    if (!drv_zero_low) begin
                        if (rx_cnt >= rx_delay) begin rx_pull_one = 0; rx_st = 0; rx_cnt = 0; end
                        else rx_cnt++;
                    end
                end
                default: if (drv_one_low && drv_zero_low) brk_len++;
                    else begin
                        chk(!drv_one_low && !drv_zero_low, "R6", "break released together",
                            int'(drv_one_low) + int'(drv_zero_low), 0);
                        chk(brk_len == BREAK_CYC, "R6", "break length", brk_len, BREAK_CYC);
                        rx_st = 0;
                    end
            endcase
            // Reference: done ends busy; both wires only during an expected break.
            if (done) begin
                chk(exp_busy == 1, "R8", "done only after a transfer", int'(exp_busy), 1);
                exp_busy = 0;
                done_cnt++;
            end
            chk(busy == exp_busy, "R8", "busy vs reference", int'(busy), int'(exp_busy));
            if (drv_one_low && drv_zero_low)
                chk(exp_break && rx_bits.size() == 8 * exp_cnt, "R7", "break not expected now",
                    1, int'(exp_break));
            if (!exp_busy)
                chk(!drv_one_low && !drv_zero_low, "R1", "drive while not busy",
                    int'(drv_one_low) + int'(drv_zero_low), 0);
        end
        // Byte feeder on the valid/ready stream.
        if (pend) begin void'(src_q.pop_front()); pend = 0; end
        in_valid = feed_en && (src_q.size() > 0);
        in_data  = in_valid ? src_q[0] : '0;
        pend     = in_valid && in_ready;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Runs one transfer with the bytes already in src_q and checks the result.
    task automatic xfer(input bit nb, input int cnt, input bit hold_ext,
                        input bit mid_start, input bit stall, input string tag);
        int base, brk0, done0, wait_n;
        exp_bytes = src_q;
        rx_bits.delete();
        brk0  = brk_seen;
        done0 = done_cnt;
        base  = nb ? BLOCK_LEN : rem_model;
        rem_model = (cnt >= base) ? 0 : base - cnt;
        exp_break = (rem_model != 0);
        exp_cnt   = cnt;
        if (hold_ext) ext_zero = 1;
        if (stall)    feed_en  = 0;
        tick(1);
        start = 1; new_block = nb; xfer_count = CNT_W'(cnt);
        tick(1);
        start = 0; new_block = 0; xfer_count = '0;
        exp_busy = 1;
        if (hold_ext || stall) begin
            tick(40);
            chk(!drv_one_low && !drv_zero_low && rx_bits.size() == 0,
                hold_ext ? "R3" : "R4", "nothing driven while blocked",
                rx_bits.size(), 0);
            ext_zero = 0; feed_en = 1;
        end
        if (mid_start) begin
            tick(20);
            start = 1; new_block = 1; xfer_count = CNT_W'(1);
            tick(1);
            start = 0; new_block = 0; xfer_count = '0;
        end
        wait_n = 0;
        while (done_cnt == done0 && wait_n < 20000) begin tick(1); wait_n++; end
        chk(done_cnt == done0 + 1, "R8", {tag, " done pulse seen"}, done_cnt - done0, 1);
        chk(rx_bits.size() == 8 * cnt, "R4", {tag, " bit count"}, rx_bits.size(), 8 * cnt);
        for (int i = 0; i < cnt && 8 * i + 7 < rx_bits.size(); i++) begin
            logic [7:0] b;
            for (int k = 0; k < 8; k++) b[7-k] = rx_bits[8*i+k];
            chk(b == exp_bytes[i], "R4", {tag, " byte MSB first"}, b, exp_bytes[i]);
        end
        chk((brk_seen - brk0) == int'(exp_break), exp_break ? "R6" : "R7",
            {tag, " break count"}, brk_seen - brk0, int'(exp_break));
        wait_n = 0;
        while ((rx_st != 0 || rx_pull_one || rx_pull_zero) && wait_n < 100) begin
            tick(1); wait_n++;
        end
        tick(4);
    endtask

    initial begin
        tick(3);
        chk(!drv_one_low && !drv_zero_low, "R1", "no drive in reset",
            int'(drv_one_low) + int'(drv_zero_low), 0);
        rst_n = 1;
        tick(2);
        chk(busy == 0 && done == 0 && in_ready == 0, "R1", "idle after reset",
            int'(busy) + int'(done) + int'(in_ready), 0);
        chk(!drv_one_low && !drv_zero_low, "R1", "wires released after reset",
            int'(drv_one_low) + int'(drv_zero_low), 0);
        monitor_on = 1;

        rx_delay = 2;   // R5: new block of 3 -> 8 left -> break (R6)
        src_q = '{8'h8B, 8'h00, 8'h00};
        xfer(1, 3, 0, 0, 0, "T2");
        rx_delay = 0;   // R5: carry 8, send 4 -> 4 left -> break
        src_q = '{8'hA5, 8'h3C, 8'hFF, 8'h01};
        xfer(0, 4, 0, 0, 0, "T3");
        rx_delay = 7;   // R7: carry 4, send 4 -> 0 left, no break
        src_q = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
        xfer(0, 4, 0, 0, 0, "T4");
        rx_delay = 1;   // R6: zero-byte transfer on a new block -> break only
        src_q.delete();
        xfer(1, 0, 0, 0, 0, "T5");
        src_q.delete(); // R5: 15 bytes on a new block clamp to zero -> R7 no break
        for (int i = 0; i < 15; i++) src_q.push_back(8'(i * 17 + 3));
        xfer(1, 15, 0, 0, 0, "T6");
        rx_delay = 3;   // R3: zero wire held low externally before start
        src_q = '{8'h81, 8'h7E};
        xfer(1, 2, 1, 0, 0, "T7");
        src_q = '{8'h55, 8'hAA};  // R9: start mid-transfer ignored, 9 -> 7 left
        xfer(0, 2, 0, 1, 0, "T8");
        src_q.delete(); // R9: remainder 7 unchanged by ignored start -> exact finish, R7
        for (int i = 0; i < 7; i++) src_q.push_back(8'(8'hF0 ^ (i * 37)));
        xfer(0, 7, 0, 0, 0, "T9");
        rx_delay = 0;   // R4: stream stalls before the first byte
        src_q = '{8'h96};
        xfer(1, 1, 0, 0, 1, "T10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule